// File: doc/BRIEF.md
# Chassis Intrusion Detection Latch

This block watches an active-low case-open input and records any opening of the enclosure in a sticky flag. When the case is closed the input idles high. When the case is opened the input goes from high to low. The raw input is asynchronous, so it passes through a two-flop synchronizer. The flag sets on the synchronized falling edge and stays set after the input returns high. Only an explicit clear from software removes it.

Software sees two views of the input through a combinational register read port: the latched event and the live, synchronized level. The flag can be cleared from either of two register write paths, a monitor-side port and a configuration-side port. Each path holds its own one-shot clear bit, which drops back to zero on the cycle after it acts. A level interrupt output follows the latched flag.

The register ports are plain control and status pins with no valid/ready handshake. A write takes effect in any cycle its strobe is high, and a read returns data in the same cycle. No back-pressure exists at any port.

Top module: `chassis_intrusion_latch`

## Requirements
- R1: A low level on `case_open_n` that is sampled at one rising clock edge sets the latched flag at the third rising edge counting that one. A low lasting only one cycle is enough to set it.
- R2: Reading address `STAT_ADDR` (default 8'h00) returns the latched flag in bit 0. After being set, the flag stays 1 while `case_open_n` is high, for as long as no clear acts.
- R3: Bit 1 at `STAT_ADDR` is 1 exactly when the synchronized input is low. It follows the pin two rising edges after the pin is sampled. All other bits at `STAT_ADDR` read 0.
- R4: A monitor write (`mon_wr`=1) to address 8'h46 with data bit 7 set clears the flag at the following edge. A monitor write with bit 7 clear has no effect. A monitor write to any other address has no effect.
- R5: A configuration write (`cfg_wr`=1) to address 8'hE6 with data bit 5 set clears the flag at the following edge. A configuration write with bit 5 clear has no effect.
- R6: Each clear bit is readable at its own address and position: 8'h46 bit 7 for the monitor path, 8'hE6 bit 5 for the configuration path. A clear bit reads 1 for the single cycle after its write and 0 after that.
- R7: If the synchronized falling edge and an active clear land on the same edge, the flag ends up set.
- R8: `intr` is high exactly while the latched flag is set.
- R9: While `rst_n` is low at a rising edge, the flag is cleared, both clear bits are cleared, and the synchronizer is loaded with the closed (high) level.
- R10: A read from any address other than the three above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| case_open_n | input | 1 | Raw case-open input, asynchronous, low means open |
| mon_wr | input | 1 | Monitor-side write strobe |
| mon_addr | input | 8 | Monitor-side write address |
| mon_wdata | input | 8 | Monitor-side write data |
| cfg_wr | input | 1 | Configuration-side write strobe |
| cfg_addr | input | 8 | Configuration-side write address |
| cfg_wdata | input | 8 | Configuration-side write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| intr | output | 1 | Level interrupt, high while the flag is set |

## Verification
The embedded properties assume three things about the inputs:
- `rst_n` is sampled only at clock edges.
- Write strobes and data are stable around each rising edge.
- `case_open_n` is held for whole clock cycles, so the check that ties a synchronized fall back to the pin's value two edges earlier is meaningful.

The stimulus respects all three. Every input changes just after a falling edge, each write strobe is held for exactly one cycle, and the case pin is driven low or high for whole cycles, including a single-cycle low pulse. The stimulus also lines up a clear with a fresh synchronized fall on the same edge, so the priority property is exercised rather than left vacuous.

// File: rtl/cio_pkg.sv
package cio_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  // One register write request as seen on either write path.
  typedef struct packed {
    logic  wr;
    addr_t addr;
    data_t data;
  } wr_req_t;
endpackage

// File: rtl/cio_sync_edge.sv
module cio_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic open_lvl,
  output logic open_fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev_q;

  // Reset loads the closed (high) level so no false edge follows reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '1;
      prev_q <= 1'b1;
    end else begin
      chain  <= {chain[SYNC_STAGES-2:0], raw_n};
      prev_q <= chain[LAST];
    end
  end

  assign open_lvl  = ~chain[LAST];
  assign open_fall = prev_q & ~chain[LAST];

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      // R1: a synchronized fall implies the pin was low two edges earlier
      a_r1_fall_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
        open_fall |-> ($past(raw_n, 2) == 1'b0));
    end
  endgenerate
endmodule

// File: rtl/cio_clear_bit.sv
module cio_clear_bit
  import cio_pkg::*;
#(
  parameter addr_t HIT_ADDR = '0,
  parameter int    HIT_BIT  = 0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wr_req_t req,
  output logic    pulse
);
  logic hit;

  assign hit = req.wr && (req.addr == HIT_ADDR) && req.data[HIT_BIT];

  // One-shot: holds 1 only for the cycle after a matching write.
  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= hit;
  end
endmodule

// File: rtl/cio_sticky.sv
module cio_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_a,
  input  logic clr_b,
  output logic flag_q
);
  // Set has priority so an event coinciding with a clear is kept.
  always_ff @(posedge clk) begin
    if (!rst_n)              flag_q <= 1'b0;
    else if (set_i)          flag_q <= 1'b1;
    else if (clr_a || clr_b) flag_q <= 1'b0;
  end

  // R7: set beats clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R4: monitor-path clear drops the flag
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a && !set_i) |=> !flag_q);
  // R5: configuration-path clear drops the flag
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_b && !set_i) |=> !flag_q);
  // R2: flag is sticky without a clear
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_a && !clr_b) |=> flag_q);
endmodule

// File: rtl/chassis_intrusion_latch.sv
module chassis_intrusion_latch
  import cio_pkg::*;
#(
  parameter addr_t STAT_ADDR      = 8'h00,
  parameter int    STAT_LATCH_BIT = 0,
  parameter int    STAT_LIVE_BIT  = 1,
  parameter addr_t MON_CLR_ADDR   = 8'h46,
  parameter int    MON_CLR_BIT    = 7,
  parameter addr_t CFG_CLR_ADDR   = 8'hE6,
  parameter int    CFG_CLR_BIT    = 5,
  parameter int    SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       case_open_n,
  input  logic       mon_wr,
  input  logic [7:0] mon_addr,
  input  logic [7:0] mon_wdata,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       intr
);
  wr_req_t mon_req, cfg_req;
  logic    open_lvl, open_fall;
  logic    mon_pulse, cfg_pulse;
  logic    flag;

  assign mon_req = '{wr: mon_wr, addr: mon_addr, data: mon_wdata};
  assign cfg_req = '{wr: cfg_wr, addr: cfg_addr, data: cfg_wdata};

  cio_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_n(case_open_n),
    .open_lvl(open_lvl), .open_fall(open_fall)
  );

  cio_clear_bit #(.HIT_ADDR(MON_CLR_ADDR), .HIT_BIT(MON_CLR_BIT)) u_mon_clr (
    .clk(clk), .rst_n(rst_n), .req(mon_req), .pulse(mon_pulse)
  );

  cio_clear_bit #(.HIT_ADDR(CFG_CLR_ADDR), .HIT_BIT(CFG_CLR_BIT)) u_cfg_clr (
    .clk(clk), .rst_n(rst_n), .req(cfg_req), .pulse(cfg_pulse)
  );

  cio_sticky u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(open_fall),
    .clr_a(mon_pulse), .clr_b(cfg_pulse), .flag_q(flag)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_ADDR) begin
      rd_data[STAT_LATCH_BIT] = flag;
      rd_data[STAT_LIVE_BIT]  = open_lvl;
    end else if (rd_addr == MON_CLR_ADDR) begin
      rd_data[MON_CLR_BIT] = mon_pulse;
    end else if (rd_addr == CFG_CLR_ADDR) begin
      rd_data[CFG_CLR_BIT] = cfg_pulse;
    end
  end

  assign intr = flag;

  // R8: interrupt pin and status read agree
  a_r8_intr_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == STAT_ADDR) |-> (rd_data[STAT_LATCH_BIT] == intr));
endmodule

// File: tb/tb_chassis_intrusion_latch.sv
module tb_chassis_intrusion_latch;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       case_open_n = 1'b1;
  logic       mon_wr = 1'b0, cfg_wr = 1'b0;
  logic [7:0] mon_addr = '0, mon_wdata = '0, cfg_addr = '0, cfg_wdata = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       intr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chassis_intrusion_latch dut (
    .clk(clk), .rst_n(rst_n), .case_open_n(case_open_n),
    .mon_wr(mon_wr), .mon_addr(mon_addr), .mon_wdata(mon_wdata),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .intr(intr)
  );

  // Behavioural reference: history of pin samples, newest first.
  logic hq[$] = '{1'b1, 1'b1, 1'b1};
  logic m_flag = 1'b0, m_mon = 1'b0, m_cfg = 1'b0;
  bit   go = 1'b0;

  always @(posedge clk) begin
    logic fall;
    if (!rst_n) begin
      hq = '{1'b1, 1'b1, 1'b1};
      m_flag = 1'b0; m_mon = 1'b0; m_cfg = 1'b0;
      go = 1'b1;
    end else begin
      fall = (hq[2] == 1'b1) && (hq[1] == 1'b0);
      if (fall)                m_flag = 1'b1;
      else if (m_mon || m_cfg) m_flag = 1'b0;
      m_mon = mon_wr && (mon_addr == 8'h46) && mon_wdata[7];
      m_cfg = cfg_wr && (cfg_addr == 8'hE6) && cfg_wdata[5];
      hq.push_front(case_open_n);
      void'(hq.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (go) begin
      chk(intr == m_flag, "R8 intr", intr, m_flag);
      if (rd_addr == 8'h00) begin
        chk(rd_data[0] == m_flag, "R2 status flag", rd_data[0], m_flag);
        chk(rd_data[7:1] == {6'b0, !hq[1]}, "R3 live bit", rd_data[7:1], {6'b0, !hq[1]});
      end else if (rd_addr == 8'h46) begin
        chk(rd_data == {m_mon, 7'b0}, "R6 monitor clear bit", rd_data, {m_mon, 7'b0});
      end else if (rd_addr == 8'hE6) begin
        chk(rd_data == {2'b0, m_cfg, 5'b0}, "R6 config clear bit", rd_data, {2'b0, m_cfg, 5'b0});
      end else begin
        chk(rd_data == 8'h00, "R10 unmapped read", rd_data, 0);
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic mon_write(input logic [7:0] a, input logic [7:0] d);
    mon_wr = 1'b1; mon_addr = a; mon_wdata = d;
    step();
    mon_wr = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    chk(rd_data == 8'h00, "R9 status after reset", rd_data, 0);
    chk(intr == 1'b0, "R9 intr after reset", intr, 0);
    rd_addr = 8'h46; step();
    chk(rd_data == 8'h00, "R9 monitor clear bit after reset", rd_data, 0);
    rd_addr = 8'hE6; step();
    chk(rd_data == 8'h00, "R9 config clear bit after reset", rd_data, 0);
    rd_addr = 8'h00; step(2);

    // R1: latency of the set path
    case_open_n = 1'b0;
    step();
    chk(rd_data[0] == 1'b0, "R1 not set after first edge", rd_data[0], 0);
    step();
    chk(rd_data[1] == 1'b1, "R3 live low after second edge", rd_data[1], 1);
    chk(rd_data[0] == 1'b0, "R1 not set after second edge", rd_data[0], 0);
    step();
    chk(rd_data[0] == 1'b1, "R1 set after third edge", rd_data[0], 1);
    case_open_n = 1'b1;
    step(4);
    chk(rd_data[0] == 1'b1, "R2 sticky after input high", rd_data[0], 1);
    chk(rd_data[1] == 1'b0, "R3 live high again", rd_data[1], 0);

    // R4 and R5: writes that must not clear
    mon_write(8'h46, 8'h7F); step();
    chk(rd_data[0] == 1'b1, "R4 bit7 clear ignored", rd_data[0], 1);
    mon_write(8'h47, 8'h80); step();
    chk(rd_data[0] == 1'b1, "R4 other address ignored", rd_data[0], 1);
    cfg_write(8'hE6, 8'hDF); step();
    chk(rd_data[0] == 1'b1, "R5 bit5 clear ignored", rd_data[0], 1);

    // R4 and R6: monitor clear path
    rd_addr = 8'h46;
    mon_write(8'h46, 8'h80);
    chk(rd_data == 8'h80, "R6 monitor clear bit high", rd_data, 8'h80);
    step();
    chk(rd_data == 8'h00, "R6 monitor clear bit self-cleared", rd_data, 0);
    rd_addr = 8'h00; step();
    chk(rd_data[0] == 1'b0, "R4 flag cleared", rd_data[0], 0);
    chk(intr == 1'b0, "R8 intr cleared", intr, 0);

    // R1: single-cycle low pulse
    case_open_n = 1'b0; step();
    case_open_n = 1'b1; step(3);
    chk(rd_data[0] == 1'b1, "R1 short pulse captured", rd_data[0], 1);

    // R5 and R6: configuration clear path
    rd_addr = 8'hE6;
    cfg_write(8'hE6, 8'h20);
    chk(rd_data == 8'h20, "R6 config clear bit high", rd_data, 8'h20);
    step();
    chk(rd_data == 8'h00, "R6 config clear bit self-cleared", rd_data, 0);
    rd_addr = 8'h00; step();
    chk(rd_data[0] == 1'b0, "R5 flag cleared", rd_data[0], 0);

    // R7: clear acting on the same edge as the synchronized fall
    case_open_n = 1'b0; step();
    mon_write(8'h46, 8'h80);
    step();
    chk(rd_data[0] == 1'b1, "R7 set wins over clear", rd_data[0], 1);
    step();
    chk(rd_data[0] == 1'b1, "R7 flag held after clash", rd_data[0], 1);

    // R10: unmapped read
    rd_addr = 8'h10; step();
    chk(rd_data == 8'h00, "R10 unmapped read", rd_data, 0);
    rd_addr = 8'h00;
    case_open_n = 1'b1; step(4);

    // R9: reset with the flag set
    rst_n = 1'b0; step();
    rst_n = 1'b1; step();
    chk(rd_data == 8'h00, "R9 reset clears flag", rd_data, 0);
    chk(intr == 1'b0, "R9 reset clears intr", intr, 0);
    step(3);
    finish_run();
  end
endmodule